// File: doc/BRIEF.md
# Two-Stage Bus-Mapped Watchdog Timer

This block is a watchdog peripheral reached over an APB-style register bus. A 32-bit down-counter, once started, counts clock cycles from a programmed reload value. When it runs out the first time, it raises a pending interrupt and starts again from the reload value. Software that is still alive answers by writing the clear register. That write drops the pending flag and restarts the count. If the counter runs out a second time while the flag is still pending, and the reset output is enabled, the block raises a system-reset request. The request stays high until the block itself is reset.

All register writes except those to the lock register are held back by a write lock. A 32-bit key opens the lock, and any other value written there closes it again. Software reads the live count, the raw and masked pending flags and the lock state, so it can work out the time left before a reset.

Top module: `twostage_wdog`

## Requirements
- R1: After reset the count (offset 0x004) and the reload value (offset 0x000) read 0xFFFFFFFF. Control (offset 0x008), raw status (offset 0x010) and masked status (offset 0x014) read 0. The lock register (offset 0xC00) reads START_LOCKED, and both irq_o and rst_o are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks, and the lock register then reads 0. Writing any other value there locks, and it then reads 1. Writes to offset 0xC00 are always accepted.
- R3: While locked, writes to the reload, control and clear registers change nothing. The reload value, the control value, the count and the pending flag all keep their values.
- R4: A write to offset 0x000 stores the reload value and loads the counter with it in the same clock edge. A written value of 0 is stored as 1. The reload register reads back the stored value.
- R5: Control bit 0 starts counting and bit 1 enables the reset output. The count falls by one per clock. Writing bit 0 from 0 to 1 reloads the counter, so a count read right after the enabling write returns the reload value minus 1.
- R6: With counting enabled, a clock edge that finds the count at 0 sets the pending flag (bit 0 of offset 0x010) and reloads the counter. The period is therefore the reload value plus 1 cycles.
- R7: The masked status bit 0 (offset 0x014) and irq_o equal the pending flag ANDed with control bit 0. Clearing bit 0 freezes the count and drops irq_o, and the raw flag is kept.
- R8: Any write to offset 0x00C clears the pending flag and reloads the counter from the reload value.
- R9: An expiry while the flag is already pending raises rst_o only if control bit 1 is set. Without bit 1, it only reloads the counter.
- R10: Once raised, rst_o stays high through later register writes until presetn is applied.
- R11: Reads of unmapped offsets and of the clear register return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during the access phase |
| irq_o | output | 1 | Masked pending interrupt |
| rst_o | output | 1 | Sticky system-reset request |

## Verification
The count is tried with a reload of 20 that is left to expire, cleared in time, and then left to expire twice with reset disabled. That run separates the first-expiry interrupt from the second-expiry reset and shows the clear acting as a keepalive. A short reload of 5 with reset enabled shows the reset request appearing and staying high through later writes until presetn is applied. Counts read right after an enabling write or a reload write separate an immediate reload from a late one. Writes made while locked, and reads after stopping, show whether the held state is really left alone.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
   localparam logic [11:0] OFS_LOAD  = 12'h000;
   localparam logic [11:0] OFS_VALUE = 12'h004;
   localparam logic [11:0] OFS_CTRL  = 12'h008;
   localparam logic [11:0] OFS_CLEAR = 12'h00C;
   localparam logic [11:0] OFS_RAW   = 12'h010;
   localparam logic [11:0] OFS_MASK  = 12'h014;
   localparam logic [11:0] OFS_LOCK  = 12'hC00;

   typedef struct packed {
      logic rst_en;
      logic run_en;
   } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 12,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551,
   parameter bit          START_LOCKED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output wd_ctrl_t          ctrl_q,
   output logic [DATA_W-1:0] load_q,
   output logic [DATA_W-1:0] load_next,
   output logic              load_wr,
   output logic              clr_wr,
   output logic              run_rise,
   output logic              locked_q
);
   localparam logic [DATA_W-1:0] LOAD_MIN = DATA_W'(1);

   logic wr_acc, open_acc, ctrl_wr, lock_wr;

   assign wr_acc   = psel && penable && pwrite;
   assign lock_wr  = wr_acc && (paddr == ADDR_W'(OFS_LOCK));
   assign open_acc = wr_acc && !locked_q;
   assign load_wr  = open_acc && (paddr == ADDR_W'(OFS_LOAD));
   assign ctrl_wr  = open_acc && (paddr == ADDR_W'(OFS_CTRL));
   assign clr_wr   = open_acc && (paddr == ADDR_W'(OFS_CLEAR));
   assign run_rise = ctrl_wr && pwdata[0] && !ctrl_q.run_en;
   assign load_next = (pwdata == '0) ? LOAD_MIN : pwdata;

   // lock state: reset value picked by variant
   generate
      if (START_LOCKED) begin : g_lock_closed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       locked_q <= 1'b1;
            else if (lock_wr) locked_q <= (pwdata != UNLOCK_KEY);
         end
      end else begin : g_lock_open
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       locked_q <= 1'b0;
            else if (lock_wr) locked_q <= (pwdata != UNLOCK_KEY);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '1;
      end else begin
         if (ctrl_wr) ctrl_q <= wd_ctrl_t'(pwdata[1:0]);
         if (load_wr) load_q <= load_next;
      end
   end

   p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && locked_q && paddr != ADDR_W'(OFS_LOCK)) |=> ($stable(ctrl_q) && $stable(load_q)));
   p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && pwdata == UNLOCK_KEY) |=> !locked_q);
   p_other_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && pwdata != UNLOCK_KEY) |=> locked_q);
   p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_q != '0);
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              rst_en,
   input  logic [DATA_W-1:0] load_q,
   input  logic [DATA_W-1:0] load_next,
   input  logic              load_wr,
   input  logic              clr_wr,
   input  logic              run_rise,
   output logic [DATA_W-1:0] count_q,
   output logic              pend_q,
   output logic              rst_q
);
   logic at_zero, expire;

   assign at_zero = (count_q == '0);
   // bus writes take priority over the counting step
   assign expire  = run_en && at_zero && !load_wr && !clr_wr && !run_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '1;
      end else if (load_wr) begin
         count_q <= load_next;
      end else if (clr_wr || run_rise) begin
         count_q <= load_q;
      end else if (run_en) begin
         count_q <= at_zero ? load_q : (count_q - 1'b1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         rst_q  <= 1'b0;
      end else begin
         if (clr_wr)      pend_q <= 1'b0;
         else if (expire) pend_q <= 1'b1;
         if (expire && pend_q && rst_en) rst_q <= 1'b1;
      end
   end

   p_expire_pends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && at_zero && !load_wr && !clr_wr && !run_rise) |=> (pend_q && count_q == $past(load_q)));
   p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !load_wr && !clr_wr && !run_rise) |=> $stable(count_q));
   p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> !pend_q);
   p_rst_after_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_q) |-> ($past(pend_q) && $past(rst_en)));
   p_rst_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> rst_q);
endmodule

// File: rtl/wdog_rdmux.sv
`timescale 1ns/1ps
module wdog_rdmux
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              psel,
   input  logic [ADDR_W-1:0] paddr,
   input  wd_ctrl_t          ctrl_q,
   input  logic [DATA_W-1:0] load_q,
   input  logic [DATA_W-1:0] count_q,
   input  logic              pend_q,
   input  logic              locked_q,
   output logic [DATA_W-1:0] prdata
);
   localparam int unsigned PAD_W = DATA_W - 2;

   always_comb begin
      prdata = '0;
      if (psel) begin
         unique case (paddr)
            ADDR_W'(OFS_LOAD):  prdata = load_q;
            ADDR_W'(OFS_VALUE): prdata = count_q;
            ADDR_W'(OFS_CTRL):  prdata = {{PAD_W{1'b0}}, ctrl_q.rst_en, ctrl_q.run_en};
            ADDR_W'(OFS_RAW):   prdata = {{PAD_W{1'b0}}, 1'b0, pend_q};
            ADDR_W'(OFS_MASK):  prdata = {{PAD_W{1'b0}}, 1'b0, pend_q & ctrl_q.run_en};
            ADDR_W'(OFS_LOCK):  prdata = {{PAD_W{1'b0}}, 1'b0, locked_q};
            default:            prdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/twostage_wdog.sv
`timescale 1ns/1ps
module twostage_wdog
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 12,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551,
   parameter bit          START_LOCKED = 1'b0
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              irq_o,
   output logic              rst_o
);
   initial begin
      assert (DATA_W >= 2 && DATA_W <= 64) else $error("DATA_W out of range");
      assert (ADDR_W >= 12) else $error("ADDR_W must reach the lock offset");
   end

   wd_ctrl_t          ctrl_q;
   logic [DATA_W-1:0] load_q, load_next, count_q;
   logic              load_wr, clr_wr, run_rise, locked_q, pend_q, rst_q;

   wdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .UNLOCK_KEY(UNLOCK_KEY), .START_LOCKED(START_LOCKED)
   ) u_regs (
      .clk(pclk), .rst_n(presetn),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata),
      .ctrl_q(ctrl_q), .load_q(load_q), .load_next(load_next),
      .load_wr(load_wr), .clr_wr(clr_wr), .run_rise(run_rise),
      .locked_q(locked_q)
   );

   wdog_core #(.DATA_W(DATA_W)) u_core (
      .clk(pclk), .rst_n(presetn),
      .run_en(ctrl_q.run_en), .rst_en(ctrl_q.rst_en),
      .load_q(load_q), .load_next(load_next),
      .load_wr(load_wr), .clr_wr(clr_wr), .run_rise(run_rise),
      .count_q(count_q), .pend_q(pend_q), .rst_q(rst_q)
   );

   wdog_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .psel(psel), .paddr(paddr), .ctrl_q(ctrl_q),
      .load_q(load_q), .count_q(count_q), .pend_q(pend_q),
      .locked_q(locked_q), .prdata(prdata)
   );

   assign irq_o = pend_q & ctrl_q.run_en;
   assign rst_o = rst_q;

   p_irq_follows_pend_r7: assert property (@(posedge pclk) disable iff (!presetn)
      $fell(ctrl_q.run_en) |-> !irq_o);
endmodule

// File: tb/sim_twostage_wdog.sv
`timescale 1ns/1ps
module sim_twostage_wdog;
   localparam int CLK_NS = 10;
   localparam logic [31:0] KEY = 32'h1ACCE551;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        irq_o, rst_o;

   logic        chk_en = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   int          n_cmp = 0, n_bad = 0;
   logic [31:0] v1, tmp;

   always #(CLK_NS/2) pclk = ~pclk;

   twostage_wdog u0 (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .irq_o(irq_o), .rst_o(rst_o)
   );

   // monitor: compares read data in the access phase against the scoreboard
   initial begin
      forever begin
         @(negedge pclk);
         #(CLK_NS/4);
         if (psel && penable && !pwrite && chk_en && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (prdata !== e) begin
               n_bad++;
               $display("FAIL %s: read 0x%08h expected 0x%08h", t, prdata, e);
            end
         end
      end
   end

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [11:0] a, input logic [31:0] e,
                         input bit chk, input string t, output logic [31:0] got);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      if (chk) begin
         exp_q.push_back(e);
         tag_q.push_back(t);
      end
      chk_en = chk;
      @(negedge pclk);
      penable = 1'b1;
      #(CLK_NS/4);
      got = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; chk_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string t);
      logic [31:0] g;
      apb_rd(a, e, 1'b1, t, g);
   endtask

   task automatic pin_chk(input logic act, input logic e, input string t);
      #1;
      n_cmp++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s: pin %0b expected %0b", t, act, e);
      end
   endtask

   task automatic do_reset();
      presetn = 1'b0;
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      @(negedge pclk);
   endtask

   initial begin
      repeat (200000) @(posedge pclk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      rd_chk(12'h004, 32'hFFFF_FFFF, "R1 value");
      rd_chk(12'h000, 32'hFFFF_FFFF, "R1 load");
      rd_chk(12'h008, 32'h0, "R1 ctrl");
      rd_chk(12'h010, 32'h0, "R1 raw");
      rd_chk(12'h014, 32'h0, "R1 masked");
      rd_chk(12'hC00, 32'h0, "R1 lock");
      pin_chk(irq_o, 1'b0, "R1 irq_o");
      pin_chk(rst_o, 1'b0, "R1 rst_o");

      // R4 reload write, R5 start counting
      apb_wr(12'h000, 32'd20);
      rd_chk(12'h000, 32'd20, "R4 load readback");
      apb_wr(12'h008, 32'h1);
      rd_chk(12'h004, 32'd19, "R5 count after enable");
      rd_chk(12'h010, 32'h0, "R6 no pending before expiry");
      repeat (28) @(negedge pclk);
      rd_chk(12'h010, 32'h1, "R6 pending after first expiry");
      rd_chk(12'h014, 32'h1, "R7 masked with enable");
      pin_chk(irq_o, 1'b1, "R7 irq_o set");
      // R8 keepalive
      apb_wr(12'h00C, 32'h0);
      rd_chk(12'h004, 32'd19, "R8 clear reloads");
      rd_chk(12'h010, 32'h0, "R8 clear drops pending");
      // R9 two expiries without reset enable
      repeat (60) @(negedge pclk);
      rd_chk(12'h010, 32'h1, "R9 pending again");
      pin_chk(rst_o, 1'b0, "R9 no reset without enable");
      // R7 stop
      apb_wr(12'h008, 32'h0);
      pin_chk(irq_o, 1'b0, "R7 irq_o drops on stop");
      rd_chk(12'h014, 32'h0, "R7 masked drops on stop");
      rd_chk(12'h010, 32'h1, "R7 raw kept on stop");
      apb_rd(12'h004, 32'h0, 1'b0, "", v1);
      repeat (5) @(negedge pclk);
      rd_chk(12'h004, v1, "R7 count frozen");
      // R2 / R3 lock
      apb_wr(12'hC00, 32'h1);
      rd_chk(12'hC00, 32'h1, "R2 lock reads 1");
      apb_wr(12'h008, 32'h3);
      apb_wr(12'h000, 32'd7);
      apb_wr(12'h00C, 32'h0);
      rd_chk(12'h008, 32'h0, "R3 ctrl unchanged");
      rd_chk(12'h000, 32'd20, "R3 load unchanged");
      rd_chk(12'h004, v1, "R3 count unchanged");
      rd_chk(12'h010, 32'h1, "R3 pending unchanged");
      pin_chk(irq_o, 1'b0, "R3 irq_o still low");
      apb_wr(12'hC00, KEY);
      rd_chk(12'hC00, 32'h0, "R2 key unlocks");
      // R5 enabling edge reloads
      apb_wr(12'h008, 32'h1);
      rd_chk(12'h004, 32'd19, "R5 enable reloads");
      rd_chk(12'h008, 32'h1, "R5 ctrl readback");
      // R4 zero clamp and immediate reload
      apb_wr(12'h000, 32'h0);
      rd_chk(12'h000, 32'h1, "R4 zero stored as one");
      apb_wr(12'h000, 32'h30);
      rd_chk(12'h004, 32'h2F, "R4 immediate reload");
      // R11 unmapped and clear reads
      rd_chk(12'h018, 32'h0, "R11 unmapped");
      rd_chk(12'h00C, 32'h0, "R11 clear reads zero");

      // R9 / R10 reset output
      apb_wr(12'h00C, 32'h0);
      apb_wr(12'h000, 32'd5);
      apb_wr(12'h008, 32'h3);
      pin_chk(rst_o, 1'b0, "R9 no reset yet");
      repeat (20) @(negedge pclk);
      pin_chk(rst_o, 1'b1, "R9 reset on second expiry");
      apb_wr(12'h008, 32'h0);
      apb_wr(12'h00C, 32'h0);
      repeat (5) @(negedge pclk);
      pin_chk(rst_o, 1'b1, "R10 reset sticky");
      do_reset();
      pin_chk(rst_o, 1'b0, "R10 reset cleared by presetn");
      rd_chk(12'h004, 32'hFFFF_FFFF, "R1 value after second reset");
      apb_rd(12'h000, 32'h0, 1'b0, "", tmp);

      repeat (3) @(negedge pclk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule